// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block sequences a processor between four operating power modes: Normal, Idle, Slow and Power-off. Software asks for a mode by pulsing `mode_wr` with a mode code on `mode_wdata`. The controller then steps through a fixed order of actions on its outputs:

- a core clock enable
- a clock-source select that picks the PLL or the crystal
- an SDRAM self-refresh request
- a supply enable for the switchable core rails

Each low-power mode has its own wake-up rule. Idle returns to Normal on any pending interrupt. Slow has no hardware wake, so only a software write of Normal ends it. Power-off ends on any external interrupt line, the RTC alarm, or the active-low battery-fault input, and it ignores every other interrupt.

The controller is a single state machine. The states and their outputs (core clock enable / crystal select / self-refresh request / supply enable / reported mode) are:

| State | Clock en | Crystal sel | SR req | Supply en | Mode |
|---|---|---|---|---|---|
| ST_NORMAL | 1 | 0 | 0 | 1 | 0 |
| ST_IDLE | 0 | 0 | 0 | 1 | 1 |
| ST_SLOW_GATE | 0 | 0 | 0 | 1 | 2 |
| ST_SLOW_SWAP | 0 | 1 | 0 | 1 | 2 |
| ST_SLOW_RUN | 1 | 1 | 0 | 1 | 2 |
| ST_SLOW_XGATE | 0 | 1 | 0 | 1 | 2 |
| ST_SLOW_XSWAP | 0 | 0 | 0 | 1 | 2 |
| ST_OFF_SREQ | 1 | 0 | 1 | 1 | 3 |
| ST_OFF_GATE | 0 | 0 | 1 | 1 | 3 |
| ST_OFF_DOWN | 0 | 0 | 1 | 0 | 3 |
| ST_OFF_SETTLE | 0 | 0 | 1 | 1 | 3 |
| ST_OFF_UNGATE | 1 | 0 | 1 | 1 | 3 |
| ST_OFF_SREXIT | 1 | 0 | 0 | 1 | 3 |

The transitions are:

| From | To | Condition |
|---|---|---|
| ST_NORMAL | ST_IDLE | Write of code 1 |
| ST_NORMAL | ST_SLOW_GATE | Write of code 2 |
| ST_NORMAL | ST_OFF_SREQ | Write of code 3 |
| ST_IDLE | ST_NORMAL | `irq_pending` high |
| ST_SLOW_GATE | ST_SLOW_SWAP | Always |
| ST_SLOW_SWAP | ST_SLOW_RUN | Always |
| ST_SLOW_RUN | ST_SLOW_XGATE | Write of code 0 |
| ST_SLOW_XGATE | ST_SLOW_XSWAP | Always |
| ST_SLOW_XSWAP | ST_NORMAL | Always |
| ST_OFF_SREQ | ST_OFF_GATE | `sr_ack` high |
| ST_OFF_GATE | ST_OFF_DOWN | Always |
| ST_OFF_DOWN | ST_OFF_SETTLE | A wake event is latched or present |
| ST_OFF_SETTLE | ST_OFF_UNGATE | Settle count reaches `settle_cycles` |
| ST_OFF_UNGATE | ST_OFF_SREXIT | Always |
| ST_OFF_SREXIT | ST_NORMAL | `sr_ack` low |

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the outputs are the ST_NORMAL values (clock enable 1, crystal select 0, self-refresh request 0, supply enable 1, mode 0), and `wake_status` is 0.
- R2: Mode codes are 0 Normal, 1 Idle, 2 Slow and 3 Power-off. A write of code 1 in Normal enters ST_IDLE on the next edge. In ST_IDLE, `irq_pending` high returns the block to ST_NORMAL on the next edge.
- R3: Mode writes are ignored in every state other than ST_NORMAL and ST_SLOW_RUN. A write of code 0 in ST_NORMAL has no effect.
- R4: Slow entry gates the core clock first, then moves the select to the crystal, then ungates. Slow exit gates first, then moves the select back to the PLL, then ungates in ST_NORMAL. The select changes only when the clock enable is low in both the previous cycle and the current one.
- R5: In ST_SLOW_RUN, `irq_pending`, the Power-off wake inputs, and writes of codes 1 to 3 have no effect. Only a write of code 0 leaves Slow.
- R6: Power-off entry raises the self-refresh request while the clock still runs. It waits in ST_OFF_SREQ until `sr_ack` is high, then gates the clock, then drops the supply enable. The supply enable is low only while the self-refresh request is high and the clock is gated.
- R7: In ST_OFF_DOWN the block wakes only on any bit of `ext_irq`, on `rtc_alarm` high, or on `batt_fault_n` low. It ignores `irq_pending`.
- R8: A wake event seen in ST_OFF_SREQ or ST_OFF_GATE is latched. The block then spends exactly one cycle in ST_OFF_DOWN before it starts the exit.
- R9: Power-off exit first raises the supply enable while the clock stays gated, for `settle_cycles`+1 cycles. It then ungates the clock, then drops the self-refresh request. It reports mode 0 only after `sr_ack` has gone low.
- R10: `wake_status` is loaded when the exit from ST_OFF_DOWN starts. Bit 2 records a battery fault, bit 1 the RTC alarm and bit 0 any external line, taken from the first latched event, or from the current inputs if none was latched. `status_clr` high clears it on the next edge. A load in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | Requested mode code |
| irq_pending | input | 1 | Any enabled interrupt pending |
| ext_irq | input | NUM_EXT | External interrupt lines, active high |
| rtc_alarm | input | 1 | RTC alarm pulse |
| batt_fault_n | input | 1 | Battery fault, active low |
| settle_cycles | input | SETTLE_W | Supply settle count after power-up |
| sr_ack | input | 1 | SDRAM self-refresh acknowledge |
| status_clr | input | 1 | Clear strobe for the wake status |
| core_clk_en | output | 1 | Core clock enable |
| clk_sel_xtal | output | 1 | 1 selects the crystal, 0 the PLL |
| sr_req | output | 1 | SDRAM self-refresh request |
| supply_en | output | 1 | Switchable core rail enable |
| mode_now | output | 2 | Reported mode code |
| wake_status | output | 3 | Cause of the last Power-off exit |

## Verification
The bench builds the block with 16 external lines and a 4-bit settle count. This lets the shortest settle (0) and the longest (15) both be reached in a few cycles. The 16-line width puts the lowest and the highest line index within reach as wake sources. A responder answers `sr_req` on `sr_ack` after a delay of two cycles, so ST_OFF_SREQ and ST_OFF_SREXIT each hold across several cycles. This also leaves room to land a wake event inside the entry sequence.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_IDLE   = 2'd1,
        MODE_SLOW   = 2'd2,
        MODE_OFF    = 2'd3
    } pm_mode_e;

    typedef enum logic [3:0] {
        ST_NORMAL,
        ST_IDLE,
        ST_SLOW_GATE,
        ST_SLOW_SWAP,
        ST_SLOW_RUN,
        ST_SLOW_XGATE,
        ST_SLOW_XSWAP,
        ST_OFF_SREQ,
        ST_OFF_GATE,
        ST_OFF_DOWN,
        ST_OFF_SETTLE,
        ST_OFF_UNGATE,
        ST_OFF_SREXIT
    } pm_state_e;

    typedef struct packed {
        logic     clk_en;
        logic     sel_xtal;
        logic     sr_req;
        logic     supply_en;
        pm_mode_e mode;
    } pm_drive_t;

    localparam int CAUSE_W = 3;

endpackage

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (!run)
            count <= '0;
        else if (count != limit)
            count <= count + 1'b1;
    end

    assign done = run && (count == limit);

endmodule

// File: rtl/pwr_wake_latch.sv
module pwr_wake_latch
    import pwr_mode_pkg::*;
#(
    parameter int NUM_EXT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] ext_irq,
    input  logic               rtc_alarm,
    input  logic               batt_fault_n,
    input  logic               window,
    input  logic               take,
    input  logic               clr,
    output logic               wake_now,
    output logic [CAUSE_W-1:0] status
);
    logic [CAUSE_W-1:0] cause_now;
    logic [CAUSE_W-1:0] held_cause;
    logic               held;

    assign cause_now = {~batt_fault_n, rtc_alarm, |ext_irq};
    assign wake_now  = held | (|cause_now);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held       <= 1'b0;
            held_cause <= '0;
        end else if (take) begin
            held       <= 1'b0;
            held_cause <= '0;
        end else if (window && !held && (|cause_now)) begin
            held       <= 1'b1;
            held_cause <= cause_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            status <= '0;
        else if (take)
            status <= held ? held_cause : cause_now;
        else if (clr)
            status <= '0;
    end

    AST_STATUS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr) && !$past(take)) |-> (status == '0)); // R10

    AST_HELD_ONLY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> $past(window)); // R8

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mode_wr,
    input  pm_mode_e  mode_req,
    input  logic      irq_pending,
    input  logic      wake_now,
    input  logic      sr_ack,
    input  logic      settle_done,
    output pm_state_e state,
    output pm_drive_t drive
);
    pm_state_e next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_NORMAL;
        else
            state <= next;
    end

    always_comb begin
        next = state;
        unique case (state)
            ST_NORMAL: begin
                if (mode_wr) begin
                    unique case (mode_req)
                        MODE_NORMAL: next = ST_NORMAL;
                        MODE_IDLE:   next = ST_IDLE;
                        MODE_SLOW:   next = ST_SLOW_GATE;
                        MODE_OFF:    next = ST_OFF_SREQ;
                    endcase
                end
            end
            ST_IDLE:       if (irq_pending) next = ST_NORMAL;
            ST_SLOW_GATE:  next = ST_SLOW_SWAP;
            ST_SLOW_SWAP:  next = ST_SLOW_RUN;
            ST_SLOW_RUN:   if (mode_wr && mode_req == MODE_NORMAL) next = ST_SLOW_XGATE;
            ST_SLOW_XGATE: next = ST_SLOW_XSWAP;
            ST_SLOW_XSWAP: next = ST_NORMAL;
            ST_OFF_SREQ:   if (sr_ack) next = ST_OFF_GATE;
            ST_OFF_GATE:   next = ST_OFF_DOWN;
            ST_OFF_DOWN:   if (wake_now) next = ST_OFF_SETTLE;
            ST_OFF_SETTLE: if (settle_done) next = ST_OFF_UNGATE;
            ST_OFF_UNGATE: next = ST_OFF_SREXIT;
            ST_OFF_SREXIT: if (!sr_ack) next = ST_NORMAL;
            default:       next = ST_NORMAL;
        endcase
    end

    always_comb begin
        drive.clk_en    = 1'b0;
        drive.sel_xtal  = 1'b0;
        drive.sr_req    = 1'b0;
        drive.supply_en = 1'b1;
        drive.mode      = MODE_NORMAL;
        unique case (state)
            ST_NORMAL:     drive.clk_en = 1'b1;
            ST_IDLE:       drive.mode = MODE_IDLE;
            ST_SLOW_GATE:  drive.mode = MODE_SLOW;
            ST_SLOW_SWAP: begin
                drive.sel_xtal = 1'b1;
                drive.mode     = MODE_SLOW;
            end
            ST_SLOW_RUN: begin
                drive.clk_en   = 1'b1;
                drive.sel_xtal = 1'b1;
                drive.mode     = MODE_SLOW;
            end
            ST_SLOW_XGATE: begin
                drive.sel_xtal = 1'b1;
                drive.mode     = MODE_SLOW;
            end
            ST_SLOW_XSWAP: drive.mode = MODE_SLOW;
            ST_OFF_SREQ: begin
                drive.clk_en = 1'b1;
                drive.sr_req = 1'b1;
                drive.mode   = MODE_OFF;
            end
            ST_OFF_GATE: begin
                drive.sr_req = 1'b1;
                drive.mode   = MODE_OFF;
            end
            ST_OFF_DOWN: begin
                drive.sr_req    = 1'b1;
                drive.supply_en = 1'b0;
                drive.mode      = MODE_OFF;
            end
            ST_OFF_SETTLE: begin
                drive.sr_req = 1'b1;
                drive.mode   = MODE_OFF;
            end
            ST_OFF_UNGATE: begin
                drive.clk_en = 1'b1;
                drive.sr_req = 1'b1;
                drive.mode   = MODE_OFF;
            end
            ST_OFF_SREXIT: begin
                drive.clk_en = 1'b1;
                drive.mode   = MODE_OFF;
            end
            default: drive.clk_en = 1'b1;
        endcase
    end

    AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && irq_pending) |=> (state == ST_NORMAL)); // R2

    AST_ACK_BEFORE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF_GATE) |-> ($past(state) == ST_OFF_SREQ && $past(sr_ack))); // R6

    AST_SLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLOW_RUN && !(mode_wr && mode_req == MODE_NORMAL)) |=> (state == ST_SLOW_RUN)); // R5

    AST_DOWN_IGNORES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF_DOWN && !wake_now) |=> (state == ST_OFF_DOWN)); // R7

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int NUM_EXT  = 16,
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_wr,
    input  logic [1:0]          mode_wdata,
    input  logic                irq_pending,
    input  logic [NUM_EXT-1:0]  ext_irq,
    input  logic                rtc_alarm,
    input  logic                batt_fault_n,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic                sr_ack,
    input  logic                status_clr,
    output logic                core_clk_en,
    output logic                clk_sel_xtal,
    output logic                sr_req,
    output logic                supply_en,
    output logic [1:0]          mode_now,
    output logic [2:0]          wake_status
);
    pm_state_e          state;
    pm_drive_t          drive;
    logic               wake_now;
    logic               settle_done;
    logic               in_window;
    logic               take_wake;
    logic [CAUSE_W-1:0] status_q;

    assign in_window = (state == ST_OFF_SREQ) || (state == ST_OFF_GATE) || (state == ST_OFF_DOWN);
    assign take_wake = (state == ST_OFF_DOWN) && wake_now;

    pwr_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_wr     (mode_wr),
        .mode_req    (pm_mode_e'(mode_wdata)),
        .irq_pending (irq_pending),
        .wake_now    (wake_now),
        .sr_ack      (sr_ack),
        .settle_done (settle_done),
        .state       (state),
        .drive       (drive)
    );

    pwr_wake_latch #(.NUM_EXT(NUM_EXT)) u_wake (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_irq      (ext_irq),
        .rtc_alarm    (rtc_alarm),
        .batt_fault_n (batt_fault_n),
        .window       (in_window),
        .take         (take_wake),
        .clr          (status_clr),
        .wake_now     (wake_now),
        .status       (status_q)
    );

    pwr_settle_timer #(.W(SETTLE_W)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_OFF_SETTLE),
        .limit (settle_cycles),
        .done  (settle_done)
    );

    assign core_clk_en  = drive.clk_en;
    assign clk_sel_xtal = drive.sel_xtal;
    assign sr_req       = drive.sr_req;
    assign supply_en    = drive.supply_en;
    assign mode_now     = drive.mode;
    assign wake_status  = status_q;

    AST_SEL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel_xtal != $past(clk_sel_xtal)) |-> (!core_clk_en && !$past(core_clk_en))); // R4

    AST_SUPPLY_OFF_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_en |-> (sr_req && !core_clk_en)); // R6

    AST_SETTLE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(supply_en) |-> (!core_clk_en && sr_req)); // R9

    AST_SREQ_DROP_CLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_req) |-> (core_clk_en && supply_en)); // R9

endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
    localparam int NUM_EXT  = 16;
    localparam int SETTLE_W = 4;

    localparam int P_NORM = 0, P_IDLE = 1, P_SG = 2, P_SS = 3, P_SLOW = 4, P_XG = 5, P_XS = 6;
    localparam int P_E1 = 7, P_E2 = 8, P_OFF = 9, P_SET = 10, P_UNG = 11, P_SRX = 12;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                mode_wr = 1'b0;
    logic [1:0]          mode_wdata = 2'd0;
    logic                irq_pending = 1'b0;
    logic [NUM_EXT-1:0]  ext_irq = '0;
    logic                rtc_alarm = 1'b0;
    logic                batt_fault_n = 1'b1;
    logic [SETTLE_W-1:0] settle_cycles = '0;
    logic                sr_ack = 1'b0;
    logic                status_clr = 1'b0;
    logic                core_clk_en, clk_sel_xtal, sr_req, supply_en;
    logic [1:0]          mode_now;
    logic [2:0]          wake_status;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string cur_req = "R1";
    logic [1:0] sr_pipe = '0;

    // reference model state
    int         ph = P_NORM;
    int         m_cnt = 0;
    bit         m_held = 0;
    logic [2:0] m_hcause = '0;
    logic [2:0] m_status = '0;

    always #2 clk = ~clk;

    pwr_mode_ctrl #(.NUM_EXT(NUM_EXT), .SETTLE_W(SETTLE_W)) u_pwr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .irq_pending(irq_pending), .ext_irq(ext_irq), .rtc_alarm(rtc_alarm),
        .batt_fault_n(batt_fault_n), .settle_cycles(settle_cycles), .sr_ack(sr_ack),
        .status_clr(status_clr), .core_clk_en(core_clk_en), .clk_sel_xtal(clk_sel_xtal),
        .sr_req(sr_req), .supply_en(supply_en), .mode_now(mode_now), .wake_status(wake_status)
    );

    // expected {clk_en, sel_xtal, sr_req, supply_en, mode} per phase (R4, R6, R9, R2)
    function automatic logic [5:0] expect_out(int p);
        logic en, sel, sr, sup;
        logic [1:0] md;
        en  = (p == P_NORM || p == P_SLOW || p == P_E1 || p == P_UNG || p == P_SRX);
        sel = (p == P_SS || p == P_SLOW || p == P_XG);
        sr  = (p >= P_E1 && p <= P_UNG);
        sup = (p != P_OFF);
        if (p == P_NORM)      md = 2'd0;
        else if (p == P_IDLE) md = 2'd1;
        else if (p <= P_XS)   md = 2'd2;
        else                  md = 2'd3;
        return {en, sel, sr, sup, md};
    endfunction

    // self-refresh responder: acknowledge follows the request after two cycles
    always @(negedge clk) begin
        sr_ack  <= sr_pipe[1];
        sr_pipe <= {sr_pipe[0], sr_req};
    end

    always @(posedge clk) begin
        logic [2:0] cause;
        bit         src;
        bit         take;
        cause = {~batt_fault_n, rtc_alarm, |ext_irq};
        src   = |cause;
        take  = 0;
        if (!rst_n) begin
            ph = P_NORM; m_cnt = 0; m_held = 0; m_hcause = '0; m_status = '0;
        end else begin
            if (ph == P_OFF && (m_held || src)) begin
                take = 1;
                m_status = m_held ? m_hcause : cause;
            end else if (status_clr) begin
                m_status = '0;
            end
            if (take) begin
                m_held = 0;
            end else if ((ph == P_E1 || ph == P_E2 || ph == P_OFF) && !m_held && src) begin
                m_held = 1; m_hcause = cause;
            end
            case (ph)
                P_NORM: if (mode_wr) ph = (mode_wdata == 2'd1) ? P_IDLE :
                                          (mode_wdata == 2'd2) ? P_SG :
                                          (mode_wdata == 2'd3) ? P_E1 : P_NORM;
                P_IDLE: if (irq_pending) ph = P_NORM;
                P_SG:   ph = P_SS;
                P_SS:   ph = P_SLOW;
                P_SLOW: if (mode_wr && mode_wdata == 2'd0) ph = P_XG;
                P_XG:   ph = P_XS;
                P_XS:   ph = P_NORM;
                P_E1:   if (sr_ack) ph = P_E2;
                P_E2:   ph = P_OFF;
                P_OFF:  if (take) begin ph = P_SET; m_cnt = 0; end
                P_SET:  if (m_cnt == int'(settle_cycles)) ph = P_UNG; else m_cnt++;
                P_UNG:  ph = P_SRX;
                P_SRX:  if (!sr_ack) ph = P_NORM;
                default: ph = P_NORM;
            endcase
        end
    end

    // per-cycle comparison with the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if ({core_clk_en, clk_sel_xtal, sr_req, supply_en, mode_now} != expect_out(ph) ||
                wake_status != m_status) begin
                errors++;
                $display("FAIL %s cycle %0d: outputs %b status %b, expected %b status %b",
                         cur_req, cycles, {core_clk_en, clk_sel_xtal, sr_req, supply_en, mode_now},
                         wake_status, expect_out(ph), m_status);
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_mode(logic [1:0] m);
        @(negedge clk);
        mode_wr = 1'b1; mode_wdata = m;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic wait_normal(string req);
        int n = 0;
        while (ph != P_NORM && n < 200) begin @(negedge clk); n++; end
        chk(req, ph, P_NORM);
        tick(1);
    endtask

    task automatic wait_phase(int p);
        int n = 0;
        while (ph != p && n < 200) begin @(negedge clk); n++; end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        // R1 reset values
        chk("R1", {core_clk_en, clk_sel_xtal, sr_req, supply_en, mode_now}, 6'b100100);
        chk("R1", wake_status, 3'b000);
        rst_n = 1'b1;
        tick(2);

        // R3 writing Normal in Normal changes nothing
        cur_req = "R3";
        write_mode(2'd0);
        tick(1);
        chk("R3", mode_now, 2'd0);

        // R2 Idle entry and wake; R3 writes ignored in Idle
        cur_req = "R2";
        write_mode(2'd1);
        chk("R2", {core_clk_en, mode_now}, 3'b0_01);
        cur_req = "R3";
        write_mode(2'd3);
        tick(2);
        chk("R3", mode_now, 2'd1);
        ext_irq = 16'h0001; tick(2); ext_irq = '0;
        chk("R2", mode_now, 2'd1);
        cur_req = "R2";
        irq_pending = 1'b1; tick(1); irq_pending = 1'b0;
        chk("R2", {core_clk_en, mode_now}, 3'b1_00);
        tick(2);

        // R4 Slow entry, R5 ignored stimulus, R4 exit
        cur_req = "R4";
        write_mode(2'd2);
        tick(3);
        chk("R4", {core_clk_en, clk_sel_xtal, mode_now}, 4'b11_10);
        cur_req = "R5";
        irq_pending = 1'b1; rtc_alarm = 1'b1; batt_fault_n = 1'b0; ext_irq = 16'h8000;
        tick(3);
        irq_pending = 1'b0; rtc_alarm = 1'b0; batt_fault_n = 1'b1; ext_irq = '0;
        write_mode(2'd1);
        write_mode(2'd3);
        tick(2);
        chk("R5", {clk_sel_xtal, mode_now}, 3'b1_10);
        cur_req = "R4";
        write_mode(2'd0);
        wait_normal("R4");
        chk("R4", clk_sel_xtal, 1'b0);

        // R6 entry, R7 wake on lowest external line, settle 0
        cur_req = "R6";
        settle_cycles = 4'd0;
        write_mode(2'd3);
        wait_phase(P_OFF);
        chk("R6", supply_en, 1'b0);
        cur_req = "R7";
        irq_pending = 1'b1; tick(4); irq_pending = 1'b0;
        chk("R7", supply_en, 1'b0);
        ext_irq = 16'h0001; tick(1); ext_irq = '0;
        cur_req = "R9";
        wait_normal("R9");
        chk("R10", wake_status, 3'b001);

        // R10 clear
        cur_req = "R10";
        status_clr = 1'b1; tick(1); status_clr = 1'b0;
        chk("R10", wake_status, 3'b000);

        // R8 RTC alarm during entry, longest settle
        cur_req = "R8";
        settle_cycles = 4'd15;
        write_mode(2'd3);
        tick(1);
        rtc_alarm = 1'b1; tick(1); rtc_alarm = 1'b0;
        wait_phase(P_OFF);
        tick(1);
        chk("R8", supply_en, 1'b1);
        cur_req = "R9";
        tick(8);
        chk("R9", {core_clk_en, supply_en}, 2'b01);
        wait_normal("R9");
        chk("R10", wake_status, 3'b010);

        // R10 battery fault plus highest line, clear held during the whole run
        cur_req = "R10";
        settle_cycles = 4'd3;
        status_clr = 1'b1;
        write_mode(2'd3);
        wait_phase(P_OFF);
        batt_fault_n = 1'b0; ext_irq = 16'h8000;
        tick(1);
        batt_fault_n = 1'b1; ext_irq = '0;
        chk("R10", wake_status, 3'b101);
        status_clr = 1'b0;
        wait_normal("R10");
        chk("R10", wake_status, 3'b101);

        tick(4);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule